// File: doc/BRIEF.md
# Pretrigger Acquisition Controller

This block sits between an ADC conversion engine and a host register interface. It stores finished conversion results in a 16-entry result FIFO. It shows whether unread data is waiting. It also keeps two sticky error flags, both active-low: one for a result lost because the FIFO was full, and one for a convert pulse that arrived while the converter was still busy.

When the host writes the clear strobe with the pretrigger mode selected, the block starts acquiring. Results are kept from that moment on. The external trigger input passes through a synchroniser. Its first rising edge starts a post-trigger sample counter, and once the programmed number of further results has been stored, acquisition stops. The host can therefore capture samples from both before and after the trigger. The same clear write empties the FIFO, resets both error flags and re-arms the trigger logic.

Top module: `pretrig_acq`

## Requirements
- R1: After reset: davail=0, ovfN=1, ovrN=1, acqActive=0, rdData=0.
- R2: The FIFO returns stored results in arrival order. A rdStrobe while davail=1 loads the oldest unread result into rdData on the next clock edge. davail is 1 exactly when at least one unread result is held.
- R3: If a result is stored while the FIFO already holds 16 results and no read happens in that cycle, the result is discarded and ovfN goes to 0. If a read and a store happen in the same cycle while the FIFO is full, the store is accepted and ovfN is unchanged.
- R4: convStart asserted while convBusy=1 during an active acquisition drives ovrN to 0 on the next edge. convStart with convBusy=0 leaves ovrN unchanged.
- R5: Once ovfN or ovrN is 0, it stays 0 until clrWr. A clrWr sets both to 1 and empties the FIFO, so davail reads 0 afterwards.
- R6: A clrWr with modePre=1 and modeHw=0 starts pre-trigger acquisition, and acqActive=1 from the next edge. A clrWr with any other mode combination leaves the block idle (acqActive=0). Only clrWr can start an acquisition.
- R7: Before the trigger edge, every convDone result is stored, with no limit other than FIFO capacity.
- R8: The first rising edge of trigIn starts the post-trigger count. The edge is seen after two synchroniser flops. After that edge, exactly postCount further results are stored, acqActive then drops to 0, and later results are ignored. With postCount=0, acquisition stops without storing any further result.
- R9: Within one armed acquisition, only the first trigger rising edge counts. Later edges do not restart the count, and trigger edges while idle have no effect.
- R10: A rdStrobe while the FIFO is empty leaves rdData at the last value read and changes no flag.
- R11: While idle, convDone stores nothing and convStart with convBusy=1 does not change ovrN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| clrWr | input | 1 | Clear-register write strobe |
| modePre | input | 1 | Pretrigger mode bit |
| modeHw | input | 1 | Hardware-trigger mode bit |
| postCount | input | CNT_W | Number of results to store after the trigger edge |
| trigIn | input | 1 | Asynchronous trigger input |
| convStart | input | 1 | External convert pulse |
| convBusy | input | 1 | ADC conversion in progress |
| convDone | input | 1 | ADC result valid strobe |
| convData | input | DATA_W | ADC result |
| rdStrobe | input | 1 | FIFO read strobe |
| rdData | output | DATA_W | Last result read from the FIFO |
| davail | output | 1 | FIFO holds unread data |
| ovfN | output | 1 | Overflow flag, active-low, sticky |
| ovrN | output | 1 | Overrun flag, active-low, sticky |
| acqActive | output | 1 | Conversions are being accepted |

## Verification
The bench fills the FIFO to exactly 16 entries and then pushes one more result. A design with an off-by-one full test would either flag overflow one result early or keep the 17th result. The bench also stores and reads in the same cycle while the FIFO is full; a design that tested fullness before the read would flag overflow falsely. For the trigger path, the bench pulses the trigger a second time in the middle of the post-trigger count and checks the exact number of results kept. It also uses a zero count, which catches a counter that restarts on every edge or stops one sample late. Reads from an empty FIFO and convert pulses while idle are checked to leave rdData and the flags untouched, and both flags are checked to survive reads until the clear strobe.

// File: rtl/pta_pkg.sv
package pta_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_POST} acqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic flush;
    logic overrun;
  } dpCtl_t;
endpackage

// File: rtl/pta_ctrl.sv
module pta_ctrl
  import pta_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clrWr,
  input  logic             modePre,
  input  logic             modeHw,
  input  logic [CNT_W-1:0] postCount,
  input  logic             trigIn,
  input  logic             convStart,
  input  logic             convBusy,
  input  logic             convDone,
  output dpCtl_t           ctl,
  output logic             acqActive
);
  acqState_t state;
  logic [CNT_W-1:0] cnt;
  logic [SYNC_STAGES-1:0] trigSync;
  logic trigPrev;
  logic trigEdge;
  logic countDone;
  logic accept;

  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) trigSync <= '0;
        else       trigSync <= {trigSync[SYNC_STAGES-2:0], trigIn};
      end
    end else begin : gSyncSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) trigSync <= '0;
        else       trigSync <= trigIn;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPrev <= 1'b0;
    else       trigPrev <= trigSync[SYNC_STAGES-1];
  end

  assign trigEdge  = trigSync[SYNC_STAGES-1] & ~trigPrev;
  assign countDone = (cnt == postCount);
  assign accept    = convDone & ~clrWr &
                     ((state == ST_PRE) | ((state == ST_POST) & ~countDone));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (clrWr) begin
      state <= (modePre & ~modeHw) ? ST_PRE : ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_PRE: if (trigEdge) begin
          state <= ST_POST;
          cnt   <= '0;
        end
        ST_POST: begin
          if (countDone)   state <= ST_IDLE;
          else if (accept) cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign acqActive   = (state != ST_IDLE);
  assign ctl.push    = accept;
  assign ctl.flush   = clrWr;
  assign ctl.overrun = convStart & convBusy & acqActive & ~clrWr;
endmodule

// File: rtl/pta_fifo_dp.sv
module pta_fifo_dp
  import pta_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              davail,
  output logic              ovfN,
  output logic              ovrN
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;
  logic full, doRd, doWr;

  assign full = (count == FULL_CNT);
  assign doRd = rdStrobe & (count != '0) & ~ctl.flush;
  assign doWr = ctl.push & (~full | doRd);

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
      ovfN   <= 1'b1;
      ovrN   <= 1'b1;
    end else if (ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovfN  <= 1'b1;
      ovrN  <= 1'b1;
    end else begin
      if (doWr) wrPtr <= wrPtr + 1'b1;
      if (doRd) begin
        rdData <= mem[rdPtr];
        rdPtr  <= rdPtr + 1'b1;
      end
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (ctl.push & full & ~doRd) ovfN <= 1'b0;
      if (ctl.overrun)             ovrN <= 1'b0;
    end
  end

  assign davail = (count != '0);
endmodule

// File: rtl/pretrig_acq.sv
module pretrig_acq
  import pta_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrWr,
  input  logic              modePre,
  input  logic              modeHw,
  input  logic [CNT_W-1:0]  postCount,
  input  logic              trigIn,
  input  logic              convStart,
  input  logic              convBusy,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              davail,
  output logic              ovfN,
  output logic              ovrN,
  output logic              acqActive
);
  dpCtl_t ctl;

  pta_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .clrWr(clrWr), .modePre(modePre), .modeHw(modeHw),
    .postCount(postCount), .trigIn(trigIn), .convStart(convStart),
    .convBusy(convBusy), .convDone(convDone), .ctl(ctl), .acqActive(acqActive)
  );

  pta_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(convData), .rdStrobe(rdStrobe),
    .rdData(rdData), .davail(davail), .ovfN(ovfN), .ovrN(ovrN)
  );
endmodule

// File: rtl/pretrig_acq_chk.sv
module pretrig_acq_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              clrWr,
  input logic              modeHw,
  input logic              convStart,
  input logic              convBusy,
  input logic              convDone,
  input logic              rdStrobe,
  input logic [DATA_W-1:0] rdData,
  input logic              davail,
  input logic              ovfN,
  input logic              ovrN,
  input logic              acqActive
);
  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfN) |-> $past(convDone));

  assert_ovr_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovrN) |-> $past(convStart && convBusy && acqActive));

  assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfN && !clrWr) |=> !ovfN);

  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ovrN && !clrWr) |=> !ovrN);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> (ovfN && ovrN && !davail));

  assert_hw_mode_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && modeHw) |=> !acqActive);

  assert_only_clear_starts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!acqActive && !clrWr) |=> !acqActive);

  assert_idle_no_store_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(davail) |-> $past(convDone && acqActive));

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!davail && !clrWr) |=> $stable(rdData));
endmodule

bind pretrig_acq pretrig_acq_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .clrWr(clrWr), .modeHw(modeHw),
  .convStart(convStart), .convBusy(convBusy), .convDone(convDone),
  .rdStrobe(rdStrobe), .rdData(rdData), .davail(davail), .ovfN(ovfN),
  .ovrN(ovrN), .acqActive(acqActive)
);

// File: tb/tb_pretrig_acq.sv
`timescale 1ns/1ps
module tb_pretrig_acq;
  localparam int DW = 12;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN, clrWr, modePre, modeHw, trigIn, convStart, convBusy, convDone, rdStrobe;
  logic [CW-1:0] postCount;
  logic [DW-1:0] convData, rdData;
  logic davail, ovfN, ovrN, acqActive;

  int nTests = 0;
  int nFail  = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pretrig_acq #(.DATA_W(DW), .DEPTH(16), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .clrWr(clrWr), .modePre(modePre), .modeHw(modeHw),
    .postCount(postCount), .trigIn(trigIn), .convStart(convStart),
    .convBusy(convBusy), .convDone(convDone), .convData(convData),
    .rdStrobe(rdStrobe), .rdData(rdData), .davail(davail), .ovfN(ovfN),
    .ovrN(ovrN), .acqActive(acqActive)
  );

  typedef struct packed {
    logic          push;
    logic          rd;
    logic [DW-1:0] data;
    logic          expDav;
    logic [DW-1:0] expRd;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 12'h011, 1'b1, 12'h000},
    '{1'b1, 1'b0, 12'h022, 1'b1, 12'h000},
    '{1'b0, 1'b1, 12'h000, 1'b1, 12'h011},
    '{1'b1, 1'b1, 12'h033, 1'b1, 12'h022},
    '{1'b0, 1'b1, 12'h000, 1'b0, 12'h033},
    '{1'b0, 1'b1, 12'h000, 1'b0, 12'h033},
    '{1'b1, 1'b0, 12'h044, 1'b1, 12'h033},
    '{1'b0, 1'b1, 12'h000, 1'b0, 12'h044}
  };

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive for one clock edge, then return at the following negedge
  task automatic step(input logic push, input logic [DW-1:0] d, input logic rd,
                      input logic st, input logic busy, input logic clr);
    convDone = push; convData = d; rdStrobe = rd;
    convStart = st; convBusy = busy; clrWr = clr;
    @(negedge clk);
    convDone = 0; rdStrobe = 0; convStart = 0; convBusy = 0; clrWr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    step(1, d, 0, 0, 0, 0);
  endtask

  task automatic rd();
    step(0, '0, 1, 0, 0, 0);
  endtask

  task automatic clr();
    step(0, '0, 0, 0, 0, 1);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      nTests++; nFail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 0; clrWr = 0; modePre = 0; modeHw = 0; trigIn = 0; convStart = 0;
    convBusy = 0; convDone = 0; rdStrobe = 0; postCount = 8'd4; convData = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 davail", davail, 0);
    check("R1 ovfN", ovfN, 1);
    check("R1 ovrN", ovrN, 1);
    check("R1 acqActive", acqActive, 0);
    check("R1 rdData", rdData, 0);

    // R11 idle ignores conversions
    push(12'h5A5);
    check("R11 idle store", davail, 0);
    step(0, '0, 0, 1, 1, 0);
    check("R11 idle overrun", ovrN, 1);

    // R6 enter pretrigger
    modePre = 1; modeHw = 0;
    clr();
    check("R6 pre mode active", acqActive, 1);

    // R2 / R10 vector table
    for (int i = 0; i < 8; i++) begin
      step(VEC[i].push, VEC[i].data, VEC[i].rd, 0, 0, 0);
      check($sformatf("R2 vec%0d davail", i), davail, VEC[i].expDav);
      check($sformatf("R2 vec%0d rdData", i), rdData, VEC[i].expRd);
    end

    // R3 overflow on 17th result, R7 pre-trigger storing
    clr();
    for (int i = 0; i < 16; i++) push(12'h100 + 12'(i));
    check("R7 16 stored ovfN", ovfN, 1);
    check("R7 davail", davail, 1);
    push(12'hEEE);
    check("R3 overflow flag", ovfN, 0);
    for (int i = 0; i < 16; i++) begin
      rd();
      check($sformatf("R3 drain %0d", i), rdData, 12'h100 + 12'(i));
    end
    check("R3 lost result davail", davail, 0);
    check("R5 ovfN sticky across reads", ovfN, 0);
    rd();
    check("R10 empty read rdData", rdData, 12'h10F);
    check("R10 empty read ovfN", ovfN, 0);
    check("R10 empty read davail", davail, 0);
    clr();
    check("R5 clear ovfN", ovfN, 1);

    // R3 full with simultaneous read and store
    for (int i = 0; i < 16; i++) push(12'h200 + 12'(i));
    step(1, 12'h2FF, 1, 0, 0, 0);
    check("R3 read+store ovfN", ovfN, 1);
    check("R3 read+store rdData", rdData, 12'h200);
    for (int i = 1; i < 16; i++) rd();
    check("R3 read+store prior", rdData, 12'h20F);
    rd();
    check("R3 read+store kept", rdData, 12'h2FF);
    check("R3 read+store empty", davail, 0);

    // R4 overrun
    clr();
    step(0, '0, 0, 1, 0, 0);
    check("R4 no busy no overrun", ovrN, 1);
    step(0, '0, 0, 1, 1, 0);
    check("R4 overrun flag", ovrN, 0);
    idle(3);
    check("R5 ovrN sticky", ovrN, 0);
    clr();
    check("R5 clear ovrN", ovrN, 1);
    check("R5 clear empties", davail, 0);

    // R8 / R9 post-trigger count of 4 with a second edge mid-count
    postCount = 8'd4;
    clr();
    push(12'h0A1); push(12'h0A2); push(12'h0A3);
    trigIn = 1;
    idle(5);
    push(12'h0B1); push(12'h0B2); push(12'h0B3);
    check("R8 active mid count", acqActive, 1);
    trigIn = 0; idle(4); trigIn = 1; idle(5);
    push(12'h0B4);
    idle(1);
    check("R9 second edge no restart", acqActive, 0);
    push(12'h0C1);
    for (int i = 0; i < 7; i++) rd();
    check("R8 last counted", rdData, 12'h0B4);
    check("R8 exact count", davail, 0);

    // R9 trigger while idle
    trigIn = 0; idle(4); trigIn = 1; idle(5);
    check("R9 idle trigger", acqActive, 0);
    push(12'h0D1);
    check("R9 idle trigger no store", davail, 0);

    // R8 zero count
    postCount = 8'd0;
    trigIn = 0;
    clr();
    idle(4);
    trigIn = 1;
    idle(6);
    check("R8 zero count stops", acqActive, 0);
    push(12'h0E1);
    check("R8 zero count no store", davail, 0);

    // R6 other modes
    modeHw = 1;
    clr();
    check("R6 hw mode idle", acqActive, 0);
    modePre = 0; modeHw = 0;
    clr();
    check("R6 no mode idle", acqActive, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule